// File: doc/BRIEF.md
# Page-mode read buffer controller

This block is the read path of a word-wide flash device, modelled in clock cycles. The address splits into a page number (upper bits) and a word index (lowest four bits). When the page number changes, or chip enable is asserted again after being high, the block starts a slow random access. It requests the whole 16-word aligned page from the storage array through a parallel port, then loads that page into a local buffer.

Later reads that change only the word index are served from the buffer after a much shorter latency. Both latencies are parameters in clock cycles. The output is one data word and a valid flag. The valid flag drops on the same clock edge that samples any address change, and rises again only when the applicable latency has run out.

The array port is a page number and a read strobe going out, and one flat vector of 16 words coming back. The array drives that vector combinationally from the page number. The buffer captures it on the edge where the random access completes.

Top module: `pbuf_read_ctrl`

## Requirements
- R1: While reset is held, and after it is released with chip enable high, `rd_valid` and `arr_rd` are both 0.
- R2: The page number is `addr[ADDR_W-1:4]` and the word index is `addr[3:0]`. A valid result equals word `addr[3:0]` of that page, where word i is taken from `arr_words[i*DATA_W +: DATA_W]`.
- R3: When `ce_n` is low and the page number differs from the buffered page, `rd_valid` rises exactly `T_ACC` clock edges after the edge that sampled the new address. During that access `arr_rd` is 1 and `arr_page` holds the new page number.
- R4: When the page number matches the buffered page and only the word index changes, `rd_valid` rises exactly `T_PACC` edges later. The data comes from the buffer, not from the current array contents.
- R5: Words within a buffered page may be read in any order, and each read costs `T_PACC`.
- R6: `ce_n` high on a clock edge clears `rd_valid` and abandons any access in progress. No result appears from that access.
- R7: When `ce_n` falls again, a full `T_ACC` access is made, even if the address is unchanged. The fresh array contents are loaded.
- R8: The edge that samples any change of `addr` while `ce_n` is low leaves `rd_valid` at 0.
- R9: A change of only the word index during a random access does not restart it. The result appears `T_ACC` edges after the access began, for the latest word index.
- R10: A change of page number during a short access or a random access starts a new random access. Its result appears `T_ACC` edges after that change, and no result is produced for the abandoned access.
- R11: While `rd_valid` stays high on consecutive edges, `rd_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Active-low chip enable |
| addr | input | ADDR_W | Word address: page number above bit 4, word index in bits 3..0 |
| rd_data | output | DATA_W | Selected word, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | Read result valid |
| arr_page | output | ADDR_W-4 | Page number requested from the storage array |
| arr_rd | output | 1 | High while a random access is loading a page |
| arr_words | input | 16*DATA_W | All 16 words of the requested page, word 0 in the low bits |

## Verification
Several events can land on the same clock edge as an access that is still counting. A new address can arrive while a random access or a short access is still in progress. Chip enable can rise while a page load is running. An address change can be sampled on the same edge where the buffered word would otherwise become valid.

The bench provokes each of these by driving the colliding input one or two cycles into an access. A scoreboard holds one expected result per access that should finish. The result is judged correct only when `rd_valid` rises on exactly the predicted cycle and the data matches, with no extra rise for an abandoned access. A generation value mixed into the array contents shows whether data came from the buffer or from a fresh load.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

  // Kind of access decided for the current cycle
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_FILL  = 2'd1,
    ACC_HIT   = 2'd2,
    ACC_ABORT = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/pbuf_access_classify.sv
module pbuf_access_classify
  import pbuf_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WSEL_W = 4,
  localparam int PAGE_W = ADDR_W - WSEL_W
) (
  input  logic              ce_n,
  input  logic              ce_n_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              tag_ok,
  input  logic [PAGE_W-1:0] tag_page,
  input  logic              fill_busy,
  input  logic [PAGE_W-1:0] fill_page,
  output acc_kind_e         kind
);

  logic [PAGE_W-1:0] page_now;
  logic [PAGE_W-1:0] ref_page;
  logic              word_moved;

  assign page_now   = addr[ADDR_W-1:WSEL_W];
  assign ref_page   = fill_busy ? fill_page : tag_page;
  assign word_moved = addr[WSEL_W-1:0] != last_addr[WSEL_W-1:0];

  always_comb begin
    if (ce_n) begin
      kind = ACC_ABORT;
    end else if (ce_n_q) begin
      kind = ACC_FILL;          // enable just re-asserted
    end else if (!fill_busy && !tag_ok) begin
      kind = ACC_FILL;
    end else if (page_now != ref_page) begin
      kind = ACC_FILL;
    end else if (fill_busy) begin
      kind = ACC_NONE;          // word moves ride along with the load
    end else if (word_moved) begin
      kind = ACC_HIT;
    end else begin
      kind = ACC_NONE;
    end
  end

endmodule

// File: rtl/pbuf_latency_timer.sv
module pbuf_latency_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             cancel,
  output logic             running,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  assign running = run_q;
  assign expire  = run_q && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = start_val;
      run_d = 1'b1;
    end else if (cancel) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (expire) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/pbuf_page_store.sv
module pbuf_page_store #(
  parameter int DATA_W = 16,
  parameter int WSEL_W = 4,
  localparam int WORDS = 1 << WSEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORDS*DATA_W-1:0] page_in,
  input  logic [WSEL_W-1:0]       sel,
  output logic [DATA_W-1:0]       word_out
);

  logic [DATA_W-1:0] words_q [WORDS];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[gi] <= '0;
      end else if (load) begin
        words_q[gi] <= page_in[gi*DATA_W +: DATA_W];
      end
    end
  end

  assign word_out = words_q[sel];

endmodule

// File: rtl/pbuf_read_ctrl.sv
module pbuf_read_ctrl
  import pbuf_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int T_ACC  = 6,
  parameter int T_PACC = 2,
  localparam int WSEL_W = 4,
  localparam int WORDS  = 1 << WSEL_W,
  localparam int PAGE_W = ADDR_W - WSEL_W,
  localparam int CNT_W  = $clog2(T_ACC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic [PAGE_W-1:0]       arr_page,
  output logic                    arr_rd,
  input  logic [WORDS*DATA_W-1:0] arr_words
);

  localparam logic [CNT_W-1:0] LAT_FILL = CNT_W'(T_ACC - 1);
  localparam logic [CNT_W-1:0] LAT_HIT  = CNT_W'(T_PACC - 1);

  // registers
  logic              ce_n_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [PAGE_W-1:0] tag_page_q, fill_page_q;
  logic              tag_ok_q, valid_q;
  logic [WSEL_W-1:0] sel_q;
  acc_kind_e         pend_q;

  // next-state values
  logic [PAGE_W-1:0] tag_page_d, fill_page_d;
  logic              tag_ok_d, valid_d;
  logic [WSEL_W-1:0] sel_d;
  acc_kind_e         pend_d;

  acc_kind_e         kind;
  logic              fill_busy;
  logic              t_start, t_cancel, t_running, t_expire;
  logic [CNT_W-1:0]  t_val;
  logic              load_page;

  assign fill_busy = (pend_q == ACC_FILL);

  pbuf_access_classify #(
    .ADDR_W (ADDR_W),
    .WSEL_W (WSEL_W)
  ) u_classify (
    .ce_n      (ce_n),
    .ce_n_q    (ce_n_q),
    .addr      (addr),
    .last_addr (last_addr_q),
    .tag_ok    (tag_ok_q),
    .tag_page  (tag_page_q),
    .fill_busy (fill_busy),
    .fill_page (fill_page_q),
    .kind      (kind)
  );

  pbuf_latency_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (t_start),
    .start_val (t_val),
    .cancel    (t_cancel),
    .running   (t_running),
    .expire    (t_expire)
  );

  pbuf_page_store #(
    .DATA_W (DATA_W),
    .WSEL_W (WSEL_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_page),
    .page_in  (arr_words),
    .sel      (sel_q),
    .word_out (rd_data)
  );

  always_comb begin
    tag_page_d  = tag_page_q;
    fill_page_d = fill_page_q;
    tag_ok_d    = tag_ok_q;
    valid_d     = valid_q;
    pend_d      = pend_q;
    sel_d       = ce_n ? sel_q : addr[WSEL_W-1:0];
    t_start     = 1'b0;
    t_cancel    = 1'b0;
    t_val       = LAT_FILL;
    load_page   = 1'b0;
    unique case (kind)
      ACC_ABORT: begin
        t_cancel = 1'b1;
        tag_ok_d = 1'b0;
        valid_d  = 1'b0;
        pend_d   = ACC_NONE;
      end
      ACC_FILL: begin
        t_start     = 1'b1;
        t_val       = LAT_FILL;
        fill_page_d = addr[ADDR_W-1:WSEL_W];
        tag_ok_d    = 1'b0;
        valid_d     = 1'b0;
        pend_d      = ACC_FILL;
      end
      ACC_HIT: begin
        t_start = 1'b1;
        t_val   = LAT_HIT;
        valid_d = 1'b0;
        pend_d  = ACC_HIT;
      end
      default: begin
        if (t_expire && t_running) begin
          valid_d = 1'b1;
          pend_d  = ACC_NONE;
          if (pend_q == ACC_FILL) begin
            load_page  = 1'b1;
            tag_page_d = fill_page_q;
            tag_ok_d   = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q      <= 1'b1;
      last_addr_q <= '0;
      tag_page_q  <= '0;
      fill_page_q <= '0;
      tag_ok_q    <= 1'b0;
      valid_q     <= 1'b0;
      sel_q       <= '0;
      pend_q      <= ACC_NONE;
    end else begin
      ce_n_q      <= ce_n;
      last_addr_q <= addr;
      tag_page_q  <= tag_page_d;
      fill_page_q <= fill_page_d;
      tag_ok_q    <= tag_ok_d;
      valid_q     <= valid_d;
      sel_q       <= sel_d;
      pend_q      <= pend_d;
    end
  end

  assign rd_valid = valid_q;
  assign arr_page = fill_page_q;
  assign arr_rd   = fill_busy;

endmodule

// File: rtl/pbuf_read_ctrl_chk.sv
module pbuf_read_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [PAGE_W-1:0] arr_page,
  input logic              arr_rd
);

  // R6: a disabled chip never reports a result on the next edge
  assert_ce_high_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rd_valid);

  // R8: the edge that samples a new address leaves valid low
  assert_addr_move_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && (addr != $past(addr))) |=> !rd_valid);

  // R11: held result does not change
  assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> $stable(rd_data));

  // R3: a result only completes while the chip was enabled
  assert_rise_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!ce_n));

  // R3: requested page is steady during a load unless the page input moved
  assert_page_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && $past(arr_rd) && ($past(addr[ADDR_W-1:ADDR_W-PAGE_W]) == $past(addr[ADDR_W-1:ADDR_W-PAGE_W], 2)))
      |-> $stable(arr_page));

  // R1/R6: no load in progress while the chip is disabled
  assert_no_load_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !arr_rd);

endmodule

bind pbuf_read_ctrl pbuf_read_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PAGE_W (PAGE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .addr     (addr),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .arr_page (arr_page),
  .arr_rd   (arr_rd)
);

// File: tb/tb_pbuf_read_ctrl.sv
`timescale 1ns/1ps
module tb_pbuf_read_ctrl;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int T_ACC  = 6;
  localparam int T_PACC = 2;
  localparam int PAGE_W = ADDR_W - 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 ce_n;
  logic [ADDR_W-1:0]    addr;
  logic [DATA_W-1:0]    rd_data;
  logic                 rd_valid;
  logic [PAGE_W-1:0]    arr_page;
  logic                 arr_rd;
  logic [16*DATA_W-1:0] arr_words;
  logic [3:0]           gen;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [DATA_W-1:0] data;
    int                due;
    string             req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pbuf_read_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .T_ACC (T_ACC), .T_PACC (T_PACC)
  ) dut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .addr (addr),
    .rd_data (rd_data), .rd_valid (rd_valid),
    .arr_page (arr_page), .arr_rd (arr_rd), .arr_words (arr_words)
  );

  function automatic logic [DATA_W-1:0] word_of(logic [PAGE_W-1:0] pg, int idx, logic [3:0] g);
    return {g, pg[7:0], 4'(idx)};
  endfunction

  always_comb begin
    for (int i = 0; i < 16; i++) arr_words[i*DATA_W +: DATA_W] = word_of(arr_page, i, gen);
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: present an address and queue the expected result
  task automatic access(logic [ADDR_W-1:0] a, int lat, logic [3:0] g, string req, bit expect_it);
    exp_t e;
    @(negedge clk);
    addr = a;
    ce_n = 1'b0;
    if (expect_it) begin
      e.data = word_of(a[ADDR_W-1:4], int'(a[3:0]), g);
      e.due  = cyc + 1 + lat;
      e.req  = req;
      sb.push_back(e);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard compare
  logic              pv = 1'b0;
  logic [DATA_W-1:0] held;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rd_valid && !pv) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected result", int'(rd_data), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, e.req, "valid cycle", cyc, e.due);
          check(rd_data == e.data, e.req, "data", int'(rd_data), int'(e.data));
        end
      end else if (rd_valid && pv) begin
        check(rd_data == held, "R11", "held data", int'(rd_data), int'(held));
      end
    end
    pv   = rd_valid;
    held = rd_data;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; addr = '0; gen = 4'd0;
    settle(3);
    check(rd_valid == 1'b0, "R1", "valid in reset", rd_valid, 0);
    check(arr_rd == 1'b0, "R1", "load in reset", arr_rd, 0);
    rst_n = 1'b1;
    settle(2);
    check(rd_valid == 1'b0, "R1", "valid after reset", rd_valid, 0);

    // R2 R3: first random access
    access(20'h00123, T_ACC, 4'd0, "R3", 1'b1);
    settle(1);
    check(arr_rd == 1'b1 && arr_page == 16'h0012, "R3", "page request", int'(arr_page), 'h12);
    settle(T_ACC + 2);

    // R4 R5: buffered words in any order, array changed meanwhile
    gen = 4'd1;
    access(20'h00127, T_PACC, 4'd0, "R4", 1'b1); settle(T_PACC + 2);
    access(20'h00120, T_PACC, 4'd0, "R5", 1'b1); settle(T_PACC + 2);
    access(20'h0012F, T_PACC, 4'd0, "R5", 1'b1); settle(T_PACC + 2);
    access(20'h00125, T_PACC, 4'd0, "R5", 1'b1); settle(T_PACC + 2);

    // R3: new page loads fresh contents
    access(20'h003A9, T_ACC, 4'd1, "R3", 1'b1); settle(T_ACC + 2);

    // R8: valid drops on the sampling edge
    access(20'h003A4, T_PACC, 4'd1, "R4", 1'b1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R8", "valid after move", rd_valid, 0);
    settle(T_PACC + 2);

    // R9: word change during load does not restart it
    access(20'h00052, T_ACC, 4'd1, "R9", 1'b0);
    begin
      exp_t e;
      e.data = word_of(16'h0005, 11, 4'd1); e.due = cyc + 1 + T_ACC; e.req = "R9";
      sb.push_back(e);
    end
    settle(2);
    addr = 20'h0005B;
    settle(T_ACC + 2);

    // R10: page change during a short access
    access(20'h00054, T_PACC, 4'd1, "R10", 1'b0);
    access(20'h00201, T_ACC, 4'd1, "R10", 1'b1);
    settle(T_ACC + 3);

    // R10: page change during a random access
    access(20'h00300, T_ACC, 4'd1, "R10", 1'b0);
    access(20'h00316, T_ACC, 4'd1, "R10", 1'b1);
    settle(T_ACC + 3);

    // R6: disable mid-load abandons it
    access(20'h00401, T_ACC, 4'd1, "R6", 1'b0);
    settle(2);
    ce_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0, "R6", "valid after disable", rd_valid, 0);
    check(arr_rd == 1'b0, "R6", "load after disable", arr_rd, 0);
    settle(T_ACC + 3);
    check(sb.size() == 0, "R6", "pending results", sb.size(), 0);

    // R7: same address after re-enable reloads with full latency
    access(20'h00401, T_ACC, 4'd1, "R7", 1'b1); settle(T_ACC + 2);
    gen = 4'd3;
    @(negedge clk); ce_n = 1'b1;
    access(20'h00401, T_ACC, 4'd3, "R7", 1'b1); settle(T_ACC + 2);
    gen = 4'd4;
    access(20'h00402, T_PACC, 4'd3, "R4", 1'b1); settle(T_PACC + 3);

    check(sb.size() == 0, "R10", "scoreboard empty", sb.size(), 0);
    finish_run();
  end

endmodule